// File: doc/BRIEF.md
# DDR2 Command Scheduler with Four-Activate Window Limit

This block chooses at most one command per clock for a DDR2 memory controller. Five traffic classes compete: refresh, column (CAS) access, scrub, read and write. Refresh and scrub requests are made inside the block by two interval timers. Column, read and write requests come from outside, each as a request line with an address. A fixed priority picks the winner among the classes that may issue in that cycle.

Two rules can hold a class back. First, scrub, read and write each open a row and so count as an ACTIVATE. A four-deep history of activate ages keeps the count of ACTIVATE commands in any rolling window of `cfg_faw` cycles at four or fewer. Second, a read whose full address equals the address of the write now requesting is a read-after-write hazard. That read waits. A class that is held back does not stall any class of lower priority.

The window length and the two interval lengths are configuration inputs. They are loaded during start-up and stay constant while the block is out of reset. Each issued command drives a one-hot bank strobe decoded from its address. A refresh drives all eight bank strobes.

Top module: `ddr_cmd_sched`

## Requirements
- R1: Among eligible classes the grant goes to the highest priority. The order from highest to lowest is refresh, CAS, scrub, read, write. The `cmd_gnt` bit positions are 0 = refresh, 1 = CAS, 2 = scrub, 3 = read, 4 = write.
- R2: At most one command issues per cycle. `cmd_valid` is high exactly when a `cmd_gnt` bit is set. `cmd_kind` encodes the winner as 0 none, 1 refresh, 2 CAS, 3 scrub, 4 read, 5 write.
- R3: The refresh timer (13-bit interval `cfg_ref_ivl` = N) reloads on reset and on a refresh grant. Its request becomes pending at the (N+1)-th rising edge after the reloading edge and stays pending until it is granted.
- R4: The scrub timer (12-bit interval `cfg_scrub_ivl`) behaves the same way as the refresh timer.
- R5: Scrub, read and write grants are ACTIVATE commands (`cmd_act` = 1). A further ACTIVATE may issue only in a cycle that is at least `cfg_faw` cycles after the fourth most recent ACTIVATE. A value of 0 for `cfg_faw` disables the limit.
- R6: A class that is held back by the activate window or by the hazard rule does not prevent an eligible class of lower priority from issuing in the same cycle. Refresh and CAS are never held back by the window.
- R7: A read is held back while `wr_req` is high and `rd_addr` equals `wr_addr` in all 32 bits. In that case the write issues.
- R8: `cmd_addr` is `cas_addr` for CAS, `rd_addr` for read and `wr_addr` for write. For refresh or no command it is zero. For scrub it is an internal pointer that is 0 after reset and increments by one on each scrub grant.
- R9: `cmd_bank` is one-hot on address bits [2:0] (bank b sets bit b) for CAS, scrub, read and write. It is all ones for refresh and all zeros when nothing issues.
- R10: After reset, nothing issues until a request arrives, no timer request is pending, and the activate history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_ivl | input | 13 | Refresh interval, constant after start-up |
| cfg_scrub_ivl | input | 12 | Scrub interval, constant after start-up |
| cfg_faw | input | 8 | Activate window length in cycles |
| cas_req | input | 1 | Column access request |
| cas_addr | input | 32 | Column access address |
| rd_req | input | 1 | Read request |
| rd_addr | input | 32 | Read address |
| wr_req | input | 1 | Write request, also marks the write as pending for the hazard rule |
| wr_addr | input | 32 | Write address |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_kind | output | 3 | Code of the issued command |
| cmd_gnt | output | 5 | One-hot grant per class |
| cmd_act | output | 1 | Issued command is an ACTIVATE |
| cmd_addr | output | 32 | Address of the issued command |
| cmd_bank | output | 8 | Bank strobes of the issued command |

## Verification
Several properties are checked on every clock. A pending refresh always wins. A column request is never stalled by anything except refresh. A read never issues against a matching write. The scrub pointer advances by one per scrub grant. A timer request neither drops without a grant nor survives one. No ACTIVATE issues while its oldest recorded predecessor is younger than the window. Some behaviour can only be shown by the bench scenarios: the exact edge on which each timer fires, the full grant pattern in which four writes pass and the fifth waits out the window, the address and bank mapping of each class, and the state right after reset.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

    localparam int NCLS     = 5;
    localparam int IX_REF   = 0;
    localparam int IX_CAS   = 1;
    localparam int IX_SCRUB = 2;
    localparam int IX_READ  = 3;
    localparam int IX_WRITE = 4;

    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_REF   = 3'd1,
        KIND_CAS   = 3'd2,
        KIND_SCRUB = 3'd3,
        KIND_READ  = 3'd4,
        KIND_WRITE = 3'd5
    } cmd_kind_e;

    typedef logic [NCLS-1:0] cls_vec_t;

    typedef struct packed {
        logic     valid;
        cmd_kind_e kind;
        logic     act;
    } cmd_info_t;

    // lowest set bit wins: bit 0 carries the highest priority
    function automatic cls_vec_t pick_first(cls_vec_t v);
        return v & (~v + cls_vec_t'(1));
    endfunction

    function automatic cmd_info_t describe(cls_vec_t g);
        cmd_info_t c;
        c.valid = |g;
        c.act   = g[IX_SCRUB] | g[IX_READ] | g[IX_WRITE];
        unique case (1'b1)
            g[IX_REF]:   c.kind = KIND_REF;
            g[IX_CAS]:   c.kind = KIND_CAS;
            g[IX_SCRUB]: c.kind = KIND_SCRUB;
            g[IX_READ]:  c.kind = KIND_READ;
            g[IX_WRITE]: c.kind = KIND_WRITE;
            default:     c.kind = KIND_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ddr_interval_timer.sv
module ddr_interval_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cfg_ivl,
    input  logic         grant,
    output logic         pend
);

    logic [W-1:0] cnt_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= cfg_ivl;
            pend_q <= 1'b0;
        end else if (grant) begin
            cnt_q  <= cfg_ivl;
            pend_q <= 1'b0;
        end else if (!pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b1;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign pend = pend_q;

    // R3 and R4: a raised request waits for its grant
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !grant) |=> pend_q) else $error("timer request dropped");

    // R3 and R4: a grant clears the request on the next edge
    p_pend_clear_r3: assert property (@(posedge clk) disable iff (rst)
        grant |=> !pend_q) else $error("timer request survived its grant");

    // R3: the arbiter grants only a pending request
    p_grant_needs_pend_r3: assert property (@(posedge clk) disable iff (rst)
        grant |-> pend_q) else $error("timer granted without request");

endmodule

// File: rtl/ddr_faw_window.sv
module ddr_faw_window #(
    parameter int NACT = 4,
    parameter int AW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_win,
    input  logic          act_i,
    output logic          ok_o
);

    logic [AW-1:0]   age_q [NACT];
    logic [NACT-1:0] vld_q;

    function automatic logic [AW-1:0] age_up(logic [AW-1:0] a);
        return (a == '1) ? a : a + 1'b1;
    endfunction

    for (genvar k = 0; k < NACT; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[k] <= '0;
                vld_q[k] <= 1'b0;
            end else if (act_i) begin
                if (k == 0) begin
                    age_q[k] <= AW'(1);
                    vld_q[k] <= 1'b1;
                end else begin
                    age_q[k] <= age_up(age_q[(k == 0) ? 0 : k-1]);
                    vld_q[k] <= vld_q[(k == 0) ? 0 : k-1];
                end
            end else begin
                age_q[k] <= age_up(age_q[k]);
            end
        end
    end

    assign ok_o = !vld_q[NACT-1] || (age_q[NACT-1] >= cfg_win);

    // R5: an activate never lands inside the window of the oldest recorded one
    p_window_r5: assert property (@(posedge clk) disable iff (rst)
        (act_i && vld_q[NACT-1]) |-> (age_q[NACT-1] >= cfg_win))
        else $error("activate inside window");

    // R10: history fills from the young end only
    p_fill_order_r10: assert property (@(posedge clk) disable iff (rst)
        vld_q[NACT-1] |-> vld_q[0]) else $error("history filled out of order");

endmodule

// File: rtl/ddr_bank_decode.sv
module ddr_bank_decode #(
    parameter int ADDR_W   = 32,
    parameter int NBANK    = 8,
    parameter int BANK_LSB = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              all_banks,
    output logic [NBANK-1:0]  sel
);

    localparam int BANK_W = $clog2(NBANK);

    logic [BANK_W-1:0] bank_idx;
    assign bank_idx = addr[BANK_LSB +: BANK_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign sel[b] = en & (all_banks | (bank_idx == BANK_W'(b)));
    end

endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched
    import ddr_sched_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int REF_W    = 13,
    parameter int SCR_W    = 12,
    parameter int FAW_W    = 8,
    parameter int NACT     = 4,
    parameter int NBANK    = 8,
    parameter int BANK_LSB = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REF_W-1:0]  cfg_ref_ivl,
    input  logic [SCR_W-1:0]  cfg_scrub_ivl,
    input  logic [FAW_W-1:0]  cfg_faw,
    input  logic              cas_req,
    input  logic [ADDR_W-1:0] cas_addr,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [NCLS-1:0]   cmd_gnt,
    output logic              cmd_act,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBANK-1:0]  cmd_bank
);

    logic              ref_pend;
    logic              scr_pend;
    logic              faw_ok;
    logic              raw_hit;
    cls_vec_t          elig;
    cls_vec_t          gnt;
    cmd_info_t         info;
    logic [ADDR_W-1:0] scrub_ptr_q;

    ddr_interval_timer #(.W(REF_W)) u_ref_timer (
        .clk(clk), .rst(rst), .cfg_ivl(cfg_ref_ivl),
        .grant(gnt[IX_REF]), .pend(ref_pend)
    );

    ddr_interval_timer #(.W(SCR_W)) u_scrub_timer (
        .clk(clk), .rst(rst), .cfg_ivl(cfg_scrub_ivl),
        .grant(gnt[IX_SCRUB]), .pend(scr_pend)
    );

    ddr_faw_window #(.NACT(NACT), .AW(FAW_W)) u_faw (
        .clk(clk), .rst(rst), .cfg_win(cfg_faw),
        .act_i(info.act), .ok_o(faw_ok)
    );

    assign raw_hit = wr_req && (rd_addr == wr_addr);

    always_comb begin
        elig           = '0;
        elig[IX_REF]   = ref_pend;
        elig[IX_CAS]   = cas_req;
        elig[IX_SCRUB] = scr_pend & faw_ok;
        elig[IX_READ]  = rd_req & faw_ok & ~raw_hit;
        elig[IX_WRITE] = wr_req & faw_ok;
    end

    assign gnt  = pick_first(elig);
    assign info = describe(gnt);

    always_ff @(posedge clk) begin
        if (rst)                 scrub_ptr_q <= '0;
        else if (gnt[IX_SCRUB])  scrub_ptr_q <= scrub_ptr_q + 1'b1;
    end

    always_comb begin
        unique case (info.kind)
            KIND_CAS:   cmd_addr = cas_addr;
            KIND_SCRUB: cmd_addr = scrub_ptr_q;
            KIND_READ:  cmd_addr = rd_addr;
            KIND_WRITE: cmd_addr = wr_addr;
            default:    cmd_addr = '0;
        endcase
    end

    ddr_bank_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_LSB(BANK_LSB)) u_bank (
        .addr(cmd_addr), .en(info.valid), .all_banks(gnt[IX_REF]), .sel(cmd_bank)
    );

    assign cmd_valid = info.valid;
    assign cmd_kind  = info.kind;
    assign cmd_gnt   = gnt;
    assign cmd_act   = info.act;

    // R1: a pending refresh always takes the slot
    p_refresh_first_r1: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> (cmd_gnt == cls_vec_t'(1))) else $error("refresh lost arbitration");

    // R6: column access is stalled only by refresh
    p_cas_not_stalled_r6: assert property (@(posedge clk) disable iff (rst)
        (cas_req && !ref_pend) |-> cmd_gnt[IX_CAS]) else $error("CAS stalled");

    // R7: no read against a matching requested write
    p_raw_block_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (rd_addr == wr_addr)) |-> !cmd_gnt[IX_READ]) else $error("RAW read issued");

    // R8: scrub pointer advances by one per scrub grant
    p_scrub_step_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_gnt[IX_SCRUB] |=> (scrub_ptr_q == $past(scrub_ptr_q) + 1'b1))
        else $error("scrub pointer step");

endmodule

// File: tb/ddr_cmd_sched_bench.sv
module ddr_cmd_sched_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] cfg_ref_ivl = 13'h1FFF;
    logic [11:0] cfg_scrub_ivl = 12'hFFF;
    logic [7:0]  cfg_faw = 8'd0;
    logic        cas_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [31:0] cas_addr = '0, rd_addr = '0, wr_addr = '0;
    logic        cmd_valid, cmd_act;
    logic [2:0]  cmd_kind;
    logic [4:0]  cmd_gnt;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_bank;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    ddr_cmd_sched u_ddr_cmd_sched (
        .clk(clk), .rst(rst), .cfg_ref_ivl(cfg_ref_ivl), .cfg_scrub_ivl(cfg_scrub_ivl),
        .cfg_faw(cfg_faw), .cas_req(cas_req), .cas_addr(cas_addr), .rd_req(rd_req),
        .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_gnt(cmd_gnt), .cmd_act(cmd_act), .cmd_addr(cmd_addr),
        .cmd_bank(cmd_bank)
    );

    typedef struct packed {
        logic        cas, rd, wr;
        logic [31:0] ca, ra, wa;
        logic [4:0]  g;
        logic [2:0]  k;
        logic [31:0] a;
        logic [7:0]  b;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0,1'b0,1'b0, 32'h0,        32'h0,        32'h0,   5'b00000, 3'd0, 32'h0,        8'h00},
        '{1'b0,1'b0,1'b1, 32'h0,        32'h0,        32'h100, 5'b10000, 3'd5, 32'h100,      8'h01},
        '{1'b0,1'b1,1'b0, 32'h0,        32'h23,       32'h0,   5'b01000, 3'd4, 32'h23,       8'h08},
        '{1'b0,1'b1,1'b1, 32'h0,        32'h45,       32'h46,  5'b01000, 3'd4, 32'h45,       8'h20},
        '{1'b0,1'b1,1'b1, 32'h0,        32'h77,       32'h77,  5'b10000, 3'd5, 32'h77,       8'h80},
        '{1'b1,1'b1,1'b1, 32'h12,       32'h45,       32'h46,  5'b00010, 3'd2, 32'h12,       8'h04},
        '{1'b1,1'b0,1'b0, 32'hFFFFFFF9, 32'h0,        32'h0,   5'b00010, 3'd2, 32'hFFFFFFF9, 8'h02},
        '{1'b0,1'b1,1'b1, 32'h0,        32'h80000004, 32'h4,   5'b01000, 3'd4, 32'h80000004, 8'h10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cas_req = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R10: quiet after reset
        do_reset();
        #1;
        chk("R10 valid after reset", {31'b0, cmd_valid}, 32'h0);
        chk("R10 bank after reset", {24'b0, cmd_bank}, 32'h0);

        // vector table: R1 R2 R7 R8 R9 with the window disabled
        for (int i = 0; i < 8; i++) begin
            cas_req = VEC[i].cas; rd_req = VEC[i].rd; wr_req = VEC[i].wr;
            cas_addr = VEC[i].ca; rd_addr = VEC[i].ra; wr_addr = VEC[i].wa;
            #1;
            chk($sformatf("R1 R7 grant vec%0d", i), {27'b0, cmd_gnt}, {27'b0, VEC[i].g});
            chk($sformatf("R2 kind vec%0d", i), {29'b0, cmd_kind}, {29'b0, VEC[i].k});
            chk($sformatf("R8 addr vec%0d", i), cmd_addr, VEC[i].a);
            chk($sformatf("R9 bank vec%0d", i), {24'b0, cmd_bank}, {24'b0, VEC[i].b});
            @(posedge clk);
            @(negedge clk);
        end

        // R3 R4 R1 R8 R9: both timers with interval 5
        cfg_ref_ivl = 13'd5;
        cfg_scrub_ivl = 12'd5;
        do_reset();
        for (int n = 1; n <= 16; n++) begin
            logic [4:0]  eg;
            logic [31:0] ea;
            logic [7:0]  eb;
            @(posedge clk);
            @(negedge clk);
            eg = 5'b0; ea = 32'h0; eb = 8'h0;
            if (n == 6 || n == 13) begin eg = 5'b00001; eb = 8'hFF; end
            if (n == 7)  begin eg = 5'b00100; ea = 32'h0; eb = 8'h01; end
            if (n == 14) begin eg = 5'b00100; ea = 32'h1; eb = 8'h02; end
            chk($sformatf("R3 R4 timer grant edge%0d", n), {27'b0, cmd_gnt}, {27'b0, eg});
            if (eg != 5'b0) begin
                chk($sformatf("R8 timer addr edge%0d", n), cmd_addr, ea);
                chk($sformatf("R9 timer bank edge%0d", n), {24'b0, cmd_bank}, {24'b0, eb});
            end
        end

        // R5 R6: window of 10 with writes held, CAS in a blocked cycle
        cfg_ref_ivl = 13'h1FFF;
        cfg_scrub_ivl = 12'hFFF;
        cfg_faw = 8'd10;
        do_reset();
        wr_req = 1'b1;
        wr_addr = 32'h2;
        for (int k = 0; k < 25; k++) begin
            logic [4:0] eg;
            cas_req = (k == 5);
            cas_addr = 32'h9;
            #1;
            if (k == 5)            eg = 5'b00010;
            else if ((k % 10) < 4) eg = 5'b10000;
            else                   eg = 5'b00000;
            if (k == 5) chk("R6 CAS during window block", {27'b0, cmd_gnt}, {27'b0, eg});
            else        chk($sformatf("R5 window cycle%0d", k), {27'b0, cmd_gnt}, {27'b0, eg});
            chk($sformatf("R5 act flag cycle%0d", k), {31'b0, cmd_act}, {31'b0, eg[4]});
            @(posedge clk);
            @(negedge clk);
        end
        wr_req = 1'b0;
        cas_req = 1'b0;

        report();
    end

endmodule